// File: doc/BRIEF.md
# Stack Pointer Limit Checker

This block owns the stack pointer of a 16-bit data path whose stack lives in byte-addressed, word-aligned data RAM and grows toward higher addresses. The pointer always names the next free word. A push stores at the pointer and then steps it up by two. A pop steps it down by two first and then reads. Every address the block derives from the pointer is compared against a software-written limit and against a fixed floor. A failing access is cancelled and raises a sticky stack-error trap.

The block also builds the two-word frame for subroutine calls and exception entry. The first word holds the low 16 program-counter bits. The second word holds the upper program-counter bits in its low byte. Its upper byte is zero for a call and carries the low status byte for an exception. The frame takes two cycles. During the second cycle `busy_o` is high and new requests are ignored. The RAM itself, trap vectoring and instruction decode live outside this block. The RAM samples `ram_addr_o`, `ram_we_o`, `ram_re_o` and `ram_wdata_o` on the rising clock edge.

Top module: `stack_guard`

## Requirements
- R1: After reset the pointer is 0x0800, the limit holds 0xFFFE, and `trap_o`, `ovf_o`, `unf_o`, `illegal_o` and `busy_o` are low.
- R2: A push drives `ram_addr_o` equal to the pointer, asserts `ram_we_o` with `ram_wdata_o` equal to `push_data_i`, and adds 2 to the pointer. A pop drives the address equal to the pointer minus 2, asserts `ram_re_o`, and subtracts 2 from the pointer. The pointer is always even.
- R3: A limit write is used by the overflow comparison from the next cycle on. A push issued in the same cycle as the write is still judged against the previous limit.
- R4: A push whose address equals the limit is allowed. A push whose address is above the limit is an overflow.
- R5: A push or pop whose address is below 0x0800 is an underflow.
- R6: An access that overflows or underflows asserts neither `ram_we_o` nor `ram_re_o` and leaves the pointer unchanged. It sets `trap_o` plus `ovf_o` or `unf_o`, and these stay high until `trap_clr_i` is asserted.
- R7: A call request writes `pc_i[15:0]` at the pointer in the request cycle. In the next cycle it writes `{8'h00, 1'b0, pc_i[22:16]}` at the pointer plus 2, and the pointer ends 4 higher. `busy_o` is high during that second cycle, and any request made then is ignored.
- R8: An exception request builds the same frame, except that the second word is `{sr_low_i, 1'b0, pc_i[22:16]}`. When a call and an exception are requested together, the exception frame is built.
- R9: When push and pop are requested in the same cycle, no access is made and the pointer is unchanged. `illegal_o` is high for exactly the following cycle.
- R10: A call or exception request is taken only when neither push nor pop is requested. Otherwise the push or pop is served alone.
- R11: If the first word of a frame fails its check, the frame is abandoned: no word is written, `busy_o` stays low, and the trap is raised as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 16 | Word to store on a push |
| call_i | input | 1 | Build a subroutine-call frame |
| exc_i | input | 1 | Build an exception-entry frame |
| pc_i | input | 23 | Program counter to save |
| sr_low_i | input | 8 | Low status byte, saved in exception frames |
| lim_we_i | input | 1 | Write the limit register |
| lim_data_i | input | 16 | New limit value (bit 0 ignored) |
| trap_clr_i | input | 1 | Clear the trap and cause flags |
| ram_addr_o | output | 16 | RAM byte address of the stack access |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 16 | RAM write data |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | Second frame word in progress |
| trap_o | output | 1 | Sticky stack-error trap |
| ovf_o | output | 1 | Sticky overflow cause |
| unf_o | output | 1 | Sticky underflow cause |
| illegal_o | output | 1 | Push and pop were requested together in the previous cycle |

## Verification
The assertions assume that the pointer never wraps past the top of the address space. Under that assumption, every granted write lies at or below the limit and every granted access lies at or above the floor. They also assume that no request is raised while reset is active. The stimulus keeps the pointer within a few words of 0x0800 and changes the limit only between the planned overflow probes. The scoreboard therefore knows in advance every address that must appear on the RAM port and every one that must be suppressed.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
  localparam int DW  = 16;
  localparam int PCW = 23;
  localparam int SRW = 8;

  typedef enum logic {FR_IDLE, FR_HI} frame_st_e;
endpackage

// File: rtl/stack_guard_ea.sv
module stack_guard_ea
  import stack_guard_pkg::*;
#(
  parameter logic [DW-1:0] FLOOR = 16'h0800
) (
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] lim_i,
  input  logic          is_push_i,
  input  logic          is_pop_i,
  output logic [DW-1:0] ea_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [DW-1:0] WORD = DW'(2);

  // pop pre-decrements, push uses the pointer as is
  assign ea_o  = is_pop_i ? sp_i - WORD : sp_i;
  // equality with the limit is still allowed
  assign ovf_o = is_push_i && (ea_o > lim_i);
  assign unf_o = (is_push_i || is_pop_i) && (ea_o < FLOOR);
endmodule

// File: rtl/stack_guard_frame.sv
module stack_guard_frame
  import stack_guard_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           exc_i,
  input  logic           fault_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_i,
  output logic           hi_o,
  output logic [DW-1:0]  hi_word_o
);
  localparam int HIW = PCW - 16;
  localparam int PAD = DW - SRW - HIW;

  frame_st_e      st_q;
  logic [DW-1:0]  hi_q;
  logic [SRW-1:0] hi_byte;

  assign hi_byte = exc_i ? sr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FR_IDLE;
      hi_q <= '0;
    end else begin
      case (st_q)
        FR_IDLE: if (start_i && !fault_i) begin
          st_q <= FR_HI;
          hi_q <= {hi_byte, {PAD{1'b0}}, pc_i[PCW-1:16]};
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign hi_o      = (st_q == FR_HI);
  assign hi_word_o = hi_q;
endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stack_guard_pkg::*;
#(
  parameter logic [DW-1:0] FLOOR  = 16'h0800,
  parameter logic [DW-1:0] SP_RST = 16'h0800,
  parameter logic [DW-1:0] LIM_RST = 16'hFFFE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic           call_i,
  input  logic           exc_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_low_i,
  input  logic           lim_we_i,
  input  logic [DW-1:0]  lim_data_i,
  input  logic           trap_clr_i,
  output logic [DW-1:0]  ram_addr_o,
  output logic           ram_we_o,
  output logic           ram_re_o,
  output logic [DW-1:0]  ram_wdata_o,
  output logic [DW-1:0]  sp_o,
  output logic           busy_o,
  output logic           trap_o,
  output logic           ovf_o,
  output logic           unf_o,
  output logic           illegal_o
);
  localparam logic [DW-1:0] WORD  = DW'(2);
  localparam logic [DW-1:0] ALIGN = ~DW'(1);

  logic [DW-1:0] sp_q, lim_q, ea, hi_word;
  logic frame_hi, req_ok, illegal_req, frame_start, is_push, is_pop;
  logic ovf, unf, fault;
  logic trap_q, ovf_q, unf_q, illegal_q;

  assign req_ok      = !frame_hi;
  assign illegal_req = req_ok && push_i && pop_i;
  assign frame_start = req_ok && !push_i && !pop_i && (call_i || exc_i);
  assign is_push     = frame_hi || frame_start || (req_ok && push_i && !pop_i);
  assign is_pop      = req_ok && pop_i && !push_i;

  stack_guard_ea #(.FLOOR(FLOOR)) u_ea (
    .sp_i     (sp_q),
    .lim_i    (lim_q),
    .is_push_i(is_push),
    .is_pop_i (is_pop),
    .ea_o     (ea),
    .ovf_o    (ovf),
    .unf_o    (unf)
  );

  assign fault = ovf || unf;

  stack_guard_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (frame_start),
    .exc_i    (exc_i),
    .fault_i  (fault),
    .pc_i     (pc_i),
    .sr_i     (sr_low_i),
    .hi_o     (frame_hi),
    .hi_word_o(hi_word)
  );

  always_comb begin
    if (frame_hi)         ram_wdata_o = hi_word;
    else if (frame_start) ram_wdata_o = pc_i[15:0];
    else                  ram_wdata_o = push_data_i;
  end

  assign ram_addr_o = ea;
  assign ram_we_o   = is_push && !fault;
  assign ram_re_o   = is_pop && !fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q      <= SP_RST & ALIGN;
      lim_q     <= LIM_RST & ALIGN;
      trap_q    <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (ram_we_o)      sp_q <= sp_q + WORD;
      else if (ram_re_o) sp_q <= sp_q - WORD;
      if (lim_we_i) lim_q <= lim_data_i & ALIGN;
      // a new fault wins over a clear in the same cycle
      if (fault)           trap_q <= 1'b1;
      else if (trap_clr_i) trap_q <= 1'b0;
      if (ovf)             ovf_q <= 1'b1;
      else if (trap_clr_i) ovf_q <= 1'b0;
      if (unf)             unf_q <= 1'b1;
      else if (trap_clr_i) unf_q <= 1'b0;
      illegal_q <= illegal_req;
    end
  end

  assign sp_o      = sp_q;
  assign busy_o    = frame_hi;
  assign trap_o    = trap_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/stack_guard_chk.sv
module stack_guard_chk
  import stack_guard_pkg::*;
#(
  parameter logic [DW-1:0] FLOOR = 16'h0800
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] sp_i,
  input logic [DW-1:0] lim_i,
  input logic [DW-1:0] addr_i,
  input logic          we_i,
  input logic          re_i,
  input logic          trap_i,
  input logic          clr_i,
  input logic          busy_i
);
  localparam logic [DW-1:0] WORD = DW'(2);

  a_r2_sp_even: assert property (@(posedge clk_i) disable iff (!rst_ni) !sp_i[0]);
  a_r2_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sp_i == $past(sp_i) + WORD);
  a_r2_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> sp_i == $past(sp_i) - WORD);
  a_r2_one_access: assert property (@(posedge clk_i) disable iff (!rst_ni) !(we_i && re_i));
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> addr_i <= lim_i);
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || re_i) |-> addr_i >= FLOOR);
  a_r6_trap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && !clr_i) |=> trap_i);
  a_r7_busy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !busy_i);
endmodule

bind stack_guard stack_guard_chk #(.FLOOR(FLOOR)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sp_i  (sp_o),
  .lim_i (lim_q),
  .addr_i(ram_addr_o),
  .we_i  (ram_we_o),
  .re_i  (ram_re_o),
  .trap_i(trap_o),
  .clr_i (trap_clr_i),
  .busy_i(busy_o)
);

// File: tb/stack_guard_bench.sv
module stack_guard_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic push_i = 0, pop_i = 0, call_i = 0, exc_i = 0, lim_we_i = 0, trap_clr_i = 0;
  logic [15:0] push_data_i = '0, lim_data_i = '0;
  logic [22:0] pc_i = '0;
  logic [7:0]  sr_low_i = '0;
  logic [15:0] ram_addr_o, ram_wdata_o, sp_o;
  logic ram_we_o, ram_re_o, busy_o, trap_o, ovf_o, unf_o, illegal_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_sp;
  logic [32:0] exp_q[$]; // {is_write, addr, data}

  always #4 clk_i = ~clk_i;

  stack_guard u_stack_guard (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of requests, from negedge to negedge
  task automatic step(input logic psh, input logic pp, input logic cl, input logic ex,
                      input logic [15:0] d, input logic lw, input logic [15:0] ld,
                      input logic clr);
    push_i = psh; pop_i = pp; call_i = cl; exc_i = ex; push_data_i = d;
    lim_we_i = lw; lim_data_i = ld; trap_clr_i = clr;
    @(negedge clk_i);
    push_i = 0; pop_i = 0; call_i = 0; exc_i = 0; lim_we_i = 0; trap_clr_i = 0;
  endtask

  task automatic push_ok(input logic [15:0] d, input string req);
    exp_q.push_back({1'b1, exp_sp, d});
    step(1, 0, 0, 0, d, 0, 0, 0);
    exp_sp += 2;
    check(req, sp_o, exp_sp);
  endtask

  task automatic pop_ok(input string req);
    exp_q.push_back({1'b0, exp_sp - 16'd2, 16'h0});
    step(0, 1, 0, 0, 0, 0, 0, 0);
    exp_sp -= 2;
    check(req, sp_o, exp_sp);
  endtask

  // monitor: compare every granted RAM access with the scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      if (rst_ni && (ram_we_o || ram_re_o)) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2/R6 unexpected access actual %h expected none",
                   {ram_we_o, ram_addr_o, ram_wdata_o});
        end else begin
          logic [32:0] e;
          logic [32:0] a;
          e = exp_q.pop_front();
          a = {ram_we_o, ram_addr_o, ram_we_o ? ram_wdata_o : 16'h0};
          if (a !== e) begin
            errors++;
            $display("FAIL R2/R7/R8 ram access actual %h expected %h", a, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_sp = 16'h0800;
    // R1 reset state
    check("R1 sp", sp_o, 16'h0800);
    check("R1 flags", {trap_o, ovf_o, unf_o, illegal_o, busy_o}, 0);

    // R2 pushes and a pop
    push_ok(16'hA001, "R2 push");
    push_ok(16'hA002, "R2 push");
    push_ok(16'hA003, "R2 push");
    pop_ok("R2 pop");
    push_ok(16'hA004, "R2 push");

    // R3 limit write with a same-cycle push uses the old limit (sp 0x0806)
    exp_q.push_back({1'b1, exp_sp, 16'hB001});
    step(1, 0, 0, 0, 16'hB001, 1, 16'h0804, 0);
    exp_sp += 2;
    check("R3 old limit in write cycle", {trap_o, sp_o}, {1'b0, exp_sp});
    step(0, 0, 0, 0, 0, 1, 16'h0808, 0);
    // R4 push at address equal to limit is allowed
    push_ok(16'hB002, "R4 push equal to limit");
    // R4 push beyond limit traps, R6 no write and sp held
    step(1, 0, 0, 0, 16'hB003, 0, 0, 0);
    check("R4 overflow trap", {trap_o, ovf_o, unf_o}, 3'b110);
    check("R6 sp held on fault", sp_o, exp_sp);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R6 trap sticky", {trap_o, ovf_o}, 2'b11);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    check("R6 trap cleared", {trap_o, ovf_o, unf_o}, 3'b000);

    // R5 underflow below the floor
    step(0, 0, 0, 0, 0, 1, 16'hFFFE, 0);
    for (int i = 0; i < 5; i++) pop_ok("R2 pop to floor");
    step(0, 1, 0, 0, 0, 0, 0, 0);
    check("R5 underflow trap", {trap_o, ovf_o, unf_o}, 3'b101);
    check("R6 sp held on underflow", sp_o, 16'h0800);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // R9 push and pop together
    step(1, 1, 0, 0, 16'hC001, 0, 0, 0);
    check("R9 illegal flagged", {illegal_o, sp_o}, {1'b1, exp_sp});
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R9 illegal one cycle", illegal_o, 0);

    // R7 call frame; push during busy is ignored
    pc_i = 23'h5A1234; sr_low_i = 8'hC3;
    exp_q.push_back({1'b1, exp_sp, 16'h1234});
    exp_q.push_back({1'b1, exp_sp + 16'd2, 16'h005A});
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R7 busy in second cycle", busy_o, 1);
    step(1, 0, 0, 0, 16'hDEAD, 0, 0, 0);
    exp_sp += 4;
    check("R7 frame sp and busy", {busy_o, sp_o}, {1'b0, exp_sp});

    // R8 exception frame wins over call
    pc_i = 23'h7FABCD;
    exp_q.push_back({1'b1, exp_sp, 16'hABCD});
    exp_q.push_back({1'b1, exp_sp + 16'd2, 16'hC37F});
    step(0, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    exp_sp += 4;
    check("R8 exception frame sp", sp_o, exp_sp);

    // R10 push served alone when a frame is also requested
    exp_q.push_back({1'b1, exp_sp, 16'hE001});
    step(1, 0, 1, 0, 16'hE001, 0, 0, 0);
    exp_sp += 2;
    check("R10 push wins over call", {busy_o, sp_o}, {1'b0, exp_sp});

    // R11 frame whose first word overflows is abandoned
    step(0, 0, 0, 0, 0, 1, 16'h0808, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R11 frame abandoned", {busy_o, trap_o, ovf_o, sp_o}, {3'b011, exp_sp});
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R11 no second word", busy_o, 0);

    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule